// File: doc/BRIEF.md
# Shared Memory-User Bus Master

This block is the single master of a bus that many memory clients share. Each client raises an interrupt line when it wants a framebuffer transfer. Whenever the master is idle it looks at those lines and picks one client. It raises that client's select line and reads two request-definition words from it over the bus. It then moves the requested number of 32-bit words between the client and a word-addressed framebuffer port, and drops the select. No other client is considered until that request has finished.

Clients 0 to `NUM_SCAN-1` are scanline caches. They take strict priority over the other clients, and among themselves the lowest index wins. Clients `NUM_SCAN` to `NUM_SCAN+NUM_GEN-1` are general clients and are granted in rotating order.

The client side of the bus works as follows. A selected client drives `bus_rdata` from the current bus address. Address 1 returns the control word, address 2 returns the start address, and address 0 returns the word at the client's local counter. A strobe tells the client to perform one access and then advance its counter.

The framebuffer side is a valid/ready request channel:
- A request is presented with `fb_req_valid` and is accepted in any cycle where `fb_req_ready` is also high.
- While a request is pending, `fb_req_addr`, `fb_req_we` and `fb_req_wdata` hold steady until it is accepted.
- Back-pressure on `fb_req_ready` stalls the bus strobe cycle by cycle.
- For a framebuffer read, `fb_rdata` must be valid in the acceptance cycle.

Top module: `mbus_master`

## Requirements
- R1: After reset, and whenever no interrupt is pending, every select line is low, the strobe is low, the bus address is 0 and no framebuffer request is valid.
- R2: When the master picks a client and any scanline-cache interrupt is high, it selects the lowest-numbered requesting scanline cache, ahead of all general clients. This holds even if general clients have been waiting longer.
- R3: General clients are granted in rotating order. The search starts at the client after the one most recently granted and wraps from the last general client to the first.
- R4: At most one select is high. Once raised, a select stays high and unchanged until its request completes. A request arriving meanwhile, even from a scanline cache, waits.
- R5: In the first cycle after a select rises, the bus address is 1. In the second cycle it is 2. In both cycles the write flag and strobe are low. Data cycles then use address 0.
- R6: Control word bit 31 sets the direction. When it is 1, client words are written to the framebuffer. When it is 0, framebuffer words are read and delivered on `bus_wdata` with `bus_write` high. Bits 30:24 and 23:12 have no effect.
- R7: The first framebuffer word address is the start address with bits 1:0 forced to zero. Each following word is 4 bytes higher.
- R8: A strobe occurs only in a cycle where the framebuffer accepts a request, and only at bus address 0. With `fb_req_ready` held high, one word moves every clock.
- R9: Exactly as many strobes are issued as the count in control word bits 11:0. With no stall, the select is high for count+2 cycles.
- R10: A count of zero issues no strobe and no framebuffer request. The select drops right after the two header cycles.
- R11: After a select drops, the bus spends one cycle with no select before the next grant. This gives the finished client a cycle to lower its interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cli_irq | input | NUM_SCAN+NUM_GEN | Request lines; scanline caches occupy the low indices |
| cli_sel | output | NUM_SCAN+NUM_GEN | One-hot select of the client being served |
| bus_addr | output | 2 | 0 = data port, 1 = control word, 2 = start address |
| bus_strobe | output | 1 | Client performs one access and advances its counter |
| bus_write | output | 1 | High when the master writes to the client |
| bus_wdata | output | 32 | Word written to the selected client |
| bus_rdata | input | 32 | Word driven by the selected client |
| fb_req_valid | output | 1 | Framebuffer request present |
| fb_req_ready | input | 1 | Framebuffer accepts the request this cycle |
| fb_req_we | output | 1 | 1 = write, 0 = read |
| fb_req_addr | output | 32 | Framebuffer byte address, word aligned |
| fb_req_wdata | output | 32 | Write data |
| fb_rdata | input | 32 | Read data, valid in the acceptance cycle |

## Verification
The bench builds the block with two scanline caches and three general clients, each client modelled behind the shared bus with its own counter and request words. Two scanline caches show lowest-index ordering among priority clients. Three general clients make the rotation pointer wrap and let a non-adjacent grant move the start point. A toggling ready pattern exercises stalls, and a zero count exercises the header-only path.

// File: rtl/mbus_pkg.sv
package mbus_pkg;
  localparam int WORD_W  = 32;
  localparam int DIR_BIT = 31;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR0,
    ST_HDR1,
    ST_DATA,
    ST_GAP
  } mb_state_e;

  localparam logic [1:0] BA_DATA = 2'd0;
  localparam logic [1:0] BA_CTRL = 2'd1;
  localparam logic [1:0] BA_BASE = 2'd2;
endpackage

// File: rtl/mbus_pick.sv
module mbus_pick #(
  parameter int N_SCAN = 2,
  parameter int N_GEN  = 4,
  localparam int N_ALL = N_SCAN + N_GEN,
  localparam int IW    = $clog2(N_ALL),
  localparam int PW    = (N_GEN > 1) ? $clog2(N_GEN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_ALL-1:0]  irq,
  input  logic              take,
  output logic              gnt_vld,
  output logic [IW-1:0]     gnt_idx
);
  logic [PW-1:0] ptr_q, ptr_nx;

  always_comb begin
    int j;
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int k = N_GEN - 1; k >= 0; k--) begin
      j = int'(ptr_q) + k;
      if (j >= N_GEN) j = j - N_GEN;
      if (irq[N_SCAN + j]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'(N_SCAN + j);
      end
    end
    for (int s = N_SCAN - 1; s >= 0; s--) begin
      if (irq[s]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'(s);
      end
    end
  end

  always_comb begin
    int nx;
    nx = int'(gnt_idx) - N_SCAN + 1;
    if (nx >= N_GEN) nx = 0;
    ptr_nx = PW'(nx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (take && gnt_idx >= IW'(N_SCAN)) ptr_q <= ptr_nx;
  end

  p_scan_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && |irq[N_SCAN-1:0]) |-> (gnt_idx < IW'(N_SCAN)));

  p_gnt_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld |-> irq[gnt_idx]);

  p_ptr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < N_GEN);
endmodule

// File: rtl/mbus_xfer.sv
module mbus_xfer
  import mbus_pkg::*;
#(
  parameter int N_ALL = 6,
  parameter int CNT_W = 12,
  localparam int IW   = $clog2(N_ALL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gnt_vld,
  input  logic [IW-1:0]     gnt_idx,
  output logic              take,
  output logic [N_ALL-1:0]  cli_sel,
  output logic [1:0]        bus_addr,
  output logic              bus_strobe,
  output logic              bus_write,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  output logic              fb_req_valid,
  input  logic              fb_req_ready,
  output logic              fb_req_we,
  output logic [WORD_W-1:0] fb_req_addr,
  output logic [WORD_W-1:0] fb_req_wdata,
  input  logic [WORD_W-1:0] fb_rdata
);
  mb_state_e         st_q;
  logic [N_ALL-1:0]  sel_q;
  logic              to_fb_q;
  logic [CNT_W-1:0]  left_q;
  logic [WORD_W-1:0] adr_q;
  logic              hs;

  assign take         = (st_q == ST_IDLE) && gnt_vld;
  assign cli_sel      = sel_q;
  assign bus_addr     = (st_q == ST_HDR0) ? BA_CTRL :
                        (st_q == ST_HDR1) ? BA_BASE : BA_DATA;
  assign fb_req_valid = (st_q == ST_DATA);
  assign fb_req_we    = to_fb_q;
  assign fb_req_addr  = adr_q;
  assign fb_req_wdata = bus_rdata;
  assign hs           = fb_req_valid && fb_req_ready;
  assign bus_strobe   = hs;
  assign bus_write    = (st_q == ST_DATA) && !to_fb_q;
  assign bus_wdata    = bus_write ? fb_rdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      sel_q   <= '0;
      to_fb_q <= 1'b0;
      left_q  <= '0;
      adr_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (take) begin
          sel_q <= {{(N_ALL-1){1'b0}}, 1'b1} << gnt_idx;
          st_q  <= ST_HDR0;
        end
        ST_HDR0: begin
          to_fb_q <= bus_rdata[DIR_BIT];
          left_q  <= bus_rdata[CNT_W-1:0];
          st_q    <= ST_HDR1;
        end
        ST_HDR1: begin
          adr_q <= {bus_rdata[WORD_W-1:2], 2'b00};
          if (left_q == '0) begin
            sel_q <= '0;
            st_q  <= ST_GAP;
          end else begin
            st_q <= ST_DATA;
          end
        end
        ST_DATA: if (hs) begin
          adr_q  <= adr_q + 32'd4;
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) begin
            sel_q <= '0;
            st_q  <= ST_GAP;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cli_sel));

  p_sel_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cli_sel != '0) |=> (cli_sel == $past(cli_sel) || cli_sel == '0));

  p_hdr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == BA_CTRL) |=> (bus_addr == BA_BASE && !bus_strobe && !bus_write));

  p_stb_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_strobe |-> (fb_req_ready && bus_addr == BA_DATA && cli_sel != '0));

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bus_strobe) && fb_req_valid) |-> (fb_req_addr == $past(fb_req_addr) + 32'd4));

  p_last_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_strobe && left_q == CNT_W'(1)) |=> (cli_sel == '0));

  p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cli_sel != '0) |=> (cli_sel == '0));
endmodule

// File: rtl/mbus_master.sv
module mbus_master #(
  parameter int NUM_SCAN = 2,
  parameter int NUM_GEN  = 4,
  parameter int CNT_W    = 12,
  localparam int NUM_CLI = NUM_SCAN + NUM_GEN,
  localparam int IDX_W   = $clog2(NUM_CLI)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_CLI-1:0] cli_irq,
  output logic [NUM_CLI-1:0] cli_sel,
  output logic [1:0]         bus_addr,
  output logic               bus_strobe,
  output logic               bus_write,
  output logic [31:0]        bus_wdata,
  input  logic [31:0]        bus_rdata,
  output logic               fb_req_valid,
  input  logic               fb_req_ready,
  output logic               fb_req_we,
  output logic [31:0]        fb_req_addr,
  output logic [31:0]        fb_req_wdata,
  input  logic [31:0]        fb_rdata
);
  logic             gnt_vld;
  logic [IDX_W-1:0] gnt_idx;
  logic             take;

  mbus_pick #(.N_SCAN(NUM_SCAN), .N_GEN(NUM_GEN)) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq     (cli_irq),
    .take    (take),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  mbus_xfer #(.N_ALL(NUM_CLI), .CNT_W(CNT_W)) u_xfer (
    .clk          (clk),
    .rst_n        (rst_n),
    .gnt_vld      (gnt_vld),
    .gnt_idx      (gnt_idx),
    .take         (take),
    .cli_sel      (cli_sel),
    .bus_addr     (bus_addr),
    .bus_strobe   (bus_strobe),
    .bus_write    (bus_write),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .fb_req_valid (fb_req_valid),
    .fb_req_ready (fb_req_ready),
    .fb_req_we    (fb_req_we),
    .fb_req_addr  (fb_req_addr),
    .fb_req_wdata (fb_req_wdata),
    .fb_rdata     (fb_rdata)
  );
endmodule

// File: tb/sim_mbus_master.sv
module sim_mbus_master;
  localparam int NS = 2;
  localparam int NG = 3;
  localparam int NC = NS + NG;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NC-1:0] irq, sel;
  logic [1:0]    baddr;
  logic          bstb, bwr, fvld, frdy, fwe;
  logic [31:0]   bwdata, brdata, faddr, fwdata, frdata;

  always #10 clk = ~clk;

  mbus_master #(.NUM_SCAN(NS), .NUM_GEN(NG), .CNT_W(12)) u0 (
    .clk(clk), .rst_n(rst_n), .cli_irq(irq), .cli_sel(sel),
    .bus_addr(baddr), .bus_strobe(bstb), .bus_write(bwr),
    .bus_wdata(bwdata), .bus_rdata(brdata),
    .fb_req_valid(fvld), .fb_req_ready(frdy), .fb_req_we(fwe),
    .fb_req_addr(faddr), .fb_req_wdata(fwdata), .fb_rdata(frdata)
  );

  // client and framebuffer models
  logic [31:0] reg0 [NC];
  logic [31:0] reg1 [NC];
  int          req_seq [NC];
  int          done_seq [NC];
  int          ptr [NC];
  logic [31:0] cmem [NC][16];
  logic [31:0] fbw [256];
  int          fbw_n = 0;
  logic [NC-1:0] sel_d = '0;
  int          cyc = 0;
  bit          stall_mode = 1'b0;

  function automatic logic [31:0] src_word(int i, int p);
    return {8'hC0 + 8'(i), 8'h00, 16'(p)};
  endfunction

  always_comb begin
    for (int i = 0; i < NC; i++) irq[i] = (req_seq[i] != done_seq[i]);
  end

  always_comb begin
    brdata = '0;
    for (int i = 0; i < NC; i++) begin
      if (sel[i]) begin
        case (baddr)
          2'd1:    brdata = reg0[i];
          2'd2:    brdata = reg1[i];
          2'd0:    brdata = src_word(i, ptr[i]);
          default: brdata = '0;
        endcase
      end
    end
  end

  assign frdata = 32'hF000_0000 ^ faddr;
  assign frdy   = stall_mode ? cyc[0] : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < NC; i++) begin
      if (!sel[i]) ptr[i] <= 0;
      else if (bstb) begin
        if (bwr) cmem[i][ptr[i][3:0]] <= bwdata;
        ptr[i] <= ptr[i] + 1;
      end
      if (sel_d[i] && !sel[i]) done_seq[i] <= done_seq[i] + 1;
    end
    if (fvld && frdy && fwe) begin
      fbw[faddr[9:2]] <= fwdata;
      fbw_n <= fbw_n + 1;
    end
    sel_d <= sel;
  end

  // per-grant bus monitor
  logic [NC-1:0] m_prev = '0, m_cur = '0;
  int m_ph = 0, m_cyc = 0, m_stb = 0, m_chk = 0, m_fail = 0, n_ord = 0;
  bit m_hdr = 1'b0, m_bad = 1'b0, m_gap = 1'b0;
  int order [64];

  always @(negedge clk) begin
    if (rst_n) begin
      if (m_gap) begin
        m_chk++;
        if (sel != '0) begin
          m_fail++;
          $display("FAIL R11 gap: sel=%b expected %b", sel, {NC{1'b0}});
        end
        m_gap = 1'b0;
      end
      if (sel != '0 && m_prev == '0) begin
        m_cur = sel; m_cyc = 1; m_ph = 1; m_bad = 1'b0;
        m_stb = bstb ? 1 : 0;
        m_hdr = (baddr == 2'd1) && !bstb && !bwr;
      end else if (sel != '0) begin
        m_cyc++;
        if (m_ph == 1) begin
          m_hdr = m_hdr && (baddr == 2'd2) && !bstb && !bwr; m_ph = 2;
        end else if (m_ph == 2) begin
          m_hdr = m_hdr && (baddr == 2'd0); m_ph = 3;
        end
        if (sel != m_cur) m_bad = 1'b1;
        if (bstb) begin
          m_stb++;
          if (!frdy || baddr != 2'd0) m_bad = 1'b1;
        end
      end else if (m_prev != '0) begin
        int idx, cnt;
        idx = 0;
        for (int i = 0; i < NC; i++) if (m_prev[i]) idx = i;
        cnt = int'(reg0[idx][11:0]);
        if (n_ord < 64) order[n_ord] = idx;
        n_ord++;
        m_chk += 3;
        if (!m_hdr) begin
          m_fail++; $display("FAIL R5 header sequence client %0d: act=0 exp=1", idx);
        end
        if (m_stb != cnt) begin
          m_fail++; $display("FAIL R9 strobes client %0d: act=%0d exp=%0d", idx, m_stb, cnt);
        end
        if (m_bad) begin
          m_fail++; $display("FAIL R4/R8 select or strobe rule client %0d: act=1 exp=0", idx);
        end
        if (!stall_mode) begin
          m_chk++;
          if (m_cyc != cnt + 2) begin
            m_fail++;
            $display("FAIL %s select cycles client %0d: act=%0d exp=%0d",
                     (cnt == 0) ? "R10" : "R9", idx, m_cyc, cnt + 2);
          end
        end
        m_gap = 1'b1;
      end
      m_prev = sel;
    end
  end

  // directed scenarios
  int t_chk = 0, t_fail = 0;
  bit wd = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    t_chk++;
    if (!ok) begin
      t_fail++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic raise(input int i, input logic [31:0] c0, input logic [31:0] c1);
    reg0[i] = c0;
    reg1[i] = c1;
    req_seq[i] = req_seq[i] + 1;
  endtask

  task automatic wait_quiet();
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (irq == '0 && sel == '0) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    check(sel == '0, "R1 sel after reset", 32'(sel), 0);
    check(!bstb && !fvld, "R1 strobe/valid after reset", {30'd0, bstb, fvld}, 0);
    check(baddr == 2'd0, "R1 address after reset", 32'(baddr), 0);
    repeat (5) @(negedge clk);
    check(sel == '0 && !bstb, "R1 idle without requests", 32'(sel), 0);
  endtask

  task automatic t_priority();
    int b;
    b = n_ord;
    for (int i = NC - 1; i >= 0; i--) raise(i, 32'h0000_0002, 32'h0000_0300 + 32'(16 * i));
    wait_quiet();
    for (int k = 0; k < NC; k++)
      check(order[b + k] == k, "R2 scanline-first order", 32'(order[b + k]), 32'(k));
  endtask

  task automatic t_rotate();
    int b;
    int exp_o [5] = '{3, 4, 1, 2, 3};
    b = n_ord;
    raise(3, 32'h0000_0001, 32'h0000_0380);
    wait_quiet();
    raise(2, 32'h0000_0003, 32'h0000_0380);
    raise(3, 32'h0000_0003, 32'h0000_0390);
    raise(4, 32'h0000_0003, 32'h0000_03A0);
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (sel[4]) break;
    end
    raise(1, 32'h0000_0001, 32'h0000_03B0);
    wait_quiet();
    for (int k = 0; k < 5; k++)
      check(order[b + k] == exp_o[k], (k == 2) ? "R4 no preemption, scanline next"
                                               : "R3 rotating order",
            32'(order[b + k]), 32'(exp_o[k]));
  endtask

  task automatic t_write();
    int n0;
    n0 = fbw_n;
    raise(2, 32'h80AB_C005, 32'h0000_0103);
    wait_quiet();
    for (int k = 0; k < 5; k++)
      check(fbw[8'h40 + 8'(k)] == src_word(2, k), "R6/R7 client-to-fb word",
            fbw[8'h40 + 8'(k)], src_word(2, k));
    check(fbw_n - n0 == 5, "R9 fb write count", 32'(fbw_n - n0), 5);
    check(fbw[8'h45] == 32'h0, "R9 no word past count", fbw[8'h45], 0);
  endtask

  task automatic t_read_stall();
    int n0;
    n0 = fbw_n;
    stall_mode = 1'b1;
    raise(0, 32'h7F00_0004, 32'h0000_0202);
    wait_quiet();
    stall_mode = 1'b0;
    for (int k = 0; k < 4; k++)
      check(cmem[0][k] == (32'hF000_0200 + 32'(4 * k)), "R6/R7/R8 fb-to-client word under stall",
            cmem[0][k], 32'hF000_0200 + 32'(4 * k));
    check(fbw_n == n0, "R6 read issues no fb write", 32'(fbw_n - n0), 0);
  endtask

  task automatic t_zero();
    int n0, b;
    n0 = fbw_n;
    b = n_ord;
    raise(4, 32'h8000_0000, 32'h0000_0000);
    wait_quiet();
    check(n_ord == b + 1 && order[b] == 4, "R10 zero-count grant completes",
          32'(n_ord - b), 1);
    check(fbw_n == n0, "R10 zero count moves nothing", 32'(fbw_n - n0), 0);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin
      reg0[i] = '0; reg1[i] = '0; req_seq[i] = 0; done_seq[i] = 0; ptr[i] = 0;
    end
    for (int a = 0; a < 256; a++) fbw[a] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fork
      begin
        t_reset();
        t_priority();
        t_rotate();
        t_write();
        t_read_stall();
        t_zero();
      end
      begin
        repeat (100000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      t_chk++; t_fail++;
      $display("FAIL watchdog: act=expired exp=finished");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", t_chk + m_chk, t_fail + m_fail);
    $finish;
  end
endmodule